// File: doc/BRIEF.md
# I2C Register-Bank Target with Auto-Incrementing Pointer

This block is an I2C target that holds twenty-two 8-bit control registers at addresses 0x00 to 0x15 and shows their contents on a parallel bus. It oversamples the SCL and SDA lines on the system clock and decodes START, repeated START and STOP from them. It matches a fixed 7-bit device address and pulls SDA low through an open-drain enable. The system clock must run at least eight times faster than SCL.

A single byte pointer serves both reads and writes. In a write, the first byte after the device address loads the pointer. Each later byte is stored at the pointer, and the pointer then steps forward. A read that names no register continues from the pointer. So it starts one past the last register touched, whether that access was a read or a write. A random read is a write that carries only the register address, followed by a repeated START and a read. In every case the pointer wraps from 0x15 back to 0x00.

The serial bus is the only data path, and its pace is set by the controller's SCL. The block never holds SCL low. So there is no valid/ready stream and no back-pressure: each byte moves as the controller clocks it, and the register outputs are plain level signals.

Top module: `i2c_regbank_target`

## Requirements
- R1: After reset, SDA is released (`sda_oe_o` = 0), every register reads 0x00 on `regs_o`, and the pointer is 0x00.
- R2: The target ACKs the address byte only when its upper seven bits equal `DEV_ADDR`. On a mismatch it leaves SDA released and ignores the bus until the next START, so later bytes store nothing.
- R3: Bit 0 of the address byte selects the direction: 0 means write and 1 means read. In a write, the first data byte loads the pointer. Each later byte is stored at the pointer, and the pointer then increments. Every received byte is ACKed.
- R4: Every increment of the pointer wraps from 0x15 to 0x00, in writes and in reads alike.
- R5: A read with no preceding pointer byte returns the register at the pointer, which is one past the last accessed register.
- R6: A write carrying only a register address, then a repeated START and a read, returns data starting at that address.
- R7: In a read, each byte is sent MSB first and the pointer increments once per byte sent. A controller ACK brings the next byte. A NACK leaves SDA released, and after a STOP SDA is always released.
- R8: A pointer value above 0x15 is still ACKed. Reads from it return 0x00, and writes to it leave every register unchanged.
- R9: `sda_oe_o` changes only while SCL is low.
- R10: A START or repeated START in the middle of a byte aborts that byte and restarts address reception. The pointer keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Sampled SCL line |
| sda_i | input | 1 | Sampled SDA line |
| sda_oe_o | output | 1 | 1 pulls SDA low (open-drain enable) |
| regs_o | output | NREG*8 | Register contents; register k sits on bits [8k+7:8k] |

## Verification
A wrong pointer shows up in the first data byte of the next read. The value returned is then a neighbouring register's contents, or 0x00 for an out-of-range pointer. A wrong write pointer shows up on `regs_o` one clock after the byte's eighth SCL falling edge. A state machine that misses a START or STOP shows up within one byte: the target ACKs in the wrong bit slot, or it drives SDA while SCL is high. The bench catches this by watching `sda_oe_o` at every clock.

// File: rtl/i2c_rb_pkg.sv
package i2c_rb_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR,
    ST_WR_ACK,
    ST_RD,
    ST_RD_ACK
  } bus_st_t;
endpackage

// File: rtl/i2c_rb_sync.sv
// Two-flop synchronizer per line, plus one extra stage for edge detection.
module i2c_rb_sync #(
  parameter int WIDTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o,
  output logic [WIDTH-1:0] prev_o
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_line
    logic meta_q, sync_q, prev_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= 1'b1;
        sync_q <= 1'b1;
        prev_q <= 1'b1;
      end else begin
        meta_q <= async_i[g];
        sync_q <= meta_q;
        prev_q <= sync_q;
      end
    end
    assign sync_o[g] = sync_q;
    assign prev_o[g] = prev_q;
  end
endmodule

// File: rtl/i2c_rb_regfile.sv
// Register bank: one write port, one combinational read port.
// Addresses at or above NREG read as zero and ignore writes.
module i2c_rb_regfile #(
  parameter int NREG = 22,
  parameter int DW   = 8,
  parameter int AW   = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [AW-1:0]      wr_addr,
  input  logic [DW-1:0]      wr_data,
  input  logic [AW-1:0]      rd_addr,
  output logic [DW-1:0]      rd_data,
  output logic [NREG*DW-1:0] regs_o
);
  localparam int IW = (NREG > 1) ? $clog2(NREG) : 1;

  logic [DW-1:0] mem [NREG];

  for (genvar k = 0; k < NREG; k++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        mem[k] <= '0;
      else if (wr_en && int'(wr_addr) == k)
        mem[k] <= wr_data;
    end
    assign regs_o[k*DW +: DW] = mem[k];
  end

  always_comb begin
    rd_data = '0;
    if (int'(rd_addr) < NREG)
      rd_data = mem[rd_addr[IW-1:0]];
  end
endmodule

// File: rtl/i2c_regbank_target.sv
module i2c_regbank_target
  import i2c_rb_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h1A,
  parameter int         NREG     = 22
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   scl_i,
  input  logic                   sda_i,
  output logic                   sda_oe_o,
  output logic [NREG*BYTE_W-1:0] regs_o
);
  localparam logic [BYTE_W-1:0] LAST = BYTE_W'(NREG - 1);

  logic [1:0] line_s, line_p;
  logic scl_s, sda_s, scl_p, sda_p;
  logic scl_rise, scl_fall, start, stop;

  i2c_rb_sync #(.WIDTH(2)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .async_i({scl_i, sda_i}),
    .sync_o(line_s), .prev_o(line_p)
  );

  assign {scl_s, sda_s} = line_s;
  assign {scl_p, sda_p} = line_p;
  assign scl_rise = scl_s & ~scl_p;
  assign scl_fall = ~scl_s & scl_p;
  assign start    = scl_s & scl_p & sda_p & ~sda_s;
  assign stop     = scl_s & scl_p & ~sda_p & sda_s;

  bus_st_t           state;
  logic [3:0]        bitcnt;
  logic [BYTE_W-1:0] shreg, ptr, ptr_next, rd_data;
  logic              rw, first, mack;
  logic              byte_done, ptr_load, wr_en, rd_load, ptr_inc;

  always_comb begin
    byte_done = scl_fall && (bitcnt == 4'd8);
    ptr_load  = (state == ST_WR) && byte_done && first;
    wr_en     = (state == ST_WR) && byte_done && !first;
    rd_load   = scl_fall && (((state == ST_ADDR_ACK) && rw) ||
                             ((state == ST_RD_ACK) && mack));
    ptr_inc   = wr_en || rd_load;
    ptr_next  = (ptr == LAST) ? '0 : ptr + BYTE_W'(1);
  end

  i2c_rb_regfile #(.NREG(NREG), .DW(BYTE_W), .AW(BYTE_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(ptr), .wr_data(shreg),
    .rd_addr(ptr), .rd_data(rd_data),
    .regs_o(regs_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      bitcnt   <= '0;
      shreg    <= '0;
      ptr      <= '0;
      rw       <= 1'b0;
      first    <= 1'b0;
      mack     <= 1'b0;
      sda_oe_o <= 1'b0;
    end else if (start) begin
      state    <= ST_ADDR;
      bitcnt   <= '0;
      first    <= 1'b1;
      sda_oe_o <= 1'b0;
    end else if (stop) begin
      state    <= ST_IDLE;
      sda_oe_o <= 1'b0;
    end else begin
      if (ptr_load)     ptr <= shreg;
      else if (ptr_inc) ptr <= ptr_next;

      if (rd_load) begin
        shreg    <= rd_data;
        sda_oe_o <= ~rd_data[BYTE_W-1];
        bitcnt   <= '0;
        state    <= ST_RD;
      end else begin
        unique case (state)
          ST_ADDR, ST_WR: begin
            if (scl_rise) begin
              shreg  <= {shreg[BYTE_W-2:0], sda_s};
              bitcnt <= bitcnt + 4'd1;
            end else if (byte_done) begin
              if (state == ST_WR) begin
                sda_oe_o <= 1'b1;
                first    <= 1'b0;
                state    <= ST_WR_ACK;
              end else if (shreg[BYTE_W-1:1] == DEV_ADDR) begin
                rw       <= shreg[0];
                sda_oe_o <= 1'b1;
                state    <= ST_ADDR_ACK;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          ST_ADDR_ACK, ST_WR_ACK: begin
            // read direction after the address ACK is handled by rd_load
            if (scl_fall) begin
              sda_oe_o <= 1'b0;
              bitcnt   <= '0;
              state    <= ST_WR;
            end
          end
          ST_RD: begin
            if (scl_fall) begin
              if (bitcnt == 4'd7) begin
                sda_oe_o <= 1'b0;
                state    <= ST_RD_ACK;
              end else begin
                shreg    <= shreg << 1;
                sda_oe_o <= ~shreg[BYTE_W-2];
                bitcnt   <= bitcnt + 4'd1;
              end
            end
          end
          ST_RD_ACK: begin
            if (scl_rise)      mack  <= ~sda_s;
            else if (scl_fall) state <= ST_IDLE;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_regbank_checker.sv
module i2c_regbank_checker #(
  parameter int NREG = 22
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   scl_s,
  input logic                   start,
  input logic                   stop,
  input logic                   sda_oe_o,
  input logic                   wr_en,
  input logic                   ptr_inc,
  input logic [7:0]             ptr,
  input logic [NREG*8-1:0]      regs_o
);
  localparam logic [7:0] LAST = 8'(NREG - 1);

  assert_sda_moves_scl_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe_o != $past(sda_oe_o)) |-> !$past(scl_s));

  assert_stop_releases_R7: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> !sda_oe_o);

  assert_regs_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(regs_o));

  assert_ptr_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_inc && ptr == LAST) |=> (ptr == 8'h00));

  assert_start_keeps_ptr_R10: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> $stable(ptr));
endmodule

bind i2c_regbank_target i2c_regbank_checker #(.NREG(NREG)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .start(start), .stop(stop),
  .sda_oe_o(sda_oe_o), .wr_en(wr_en), .ptr_inc(ptr_inc), .ptr(ptr),
  .regs_o(regs_o)
);

// File: tb/i2c_regbank_target_bench.sv
`timescale 1ns/1ps
module i2c_regbank_target_bench;
  localparam logic [6:0] DEV = 7'h1A;
  localparam int NREG = 22;
  localparam int HP = 10;
  localparam int QP = 5;
  localparam int NVEC = 8;
  // {register address, data}
  localparam logic [15:0] VEC [NVEC] = '{16'h005A, 16'h15C3, 16'h0781, 16'h013C,
                                        16'h0AFF, 16'h1401, 16'h1096, 16'h03E7};

  logic clk = 0, rst_n = 0, scl_m = 1, sda_m = 1;
  logic sda_oe;
  logic [NREG*8-1:0] regs;
  wire sda_line = sda_m & ~sda_oe;
  int errors = 0, checks = 0, viol = 0;
  logic [7:0] model [NREG];
  logic done = 0;

  always #10 clk = ~clk;

  i2c_regbank_target #(.DEV_ADDR(DEV), .NREG(NREG)) u_i2c_regbank_target (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .regs_o(regs)
  );

  // R9 monitor: output enable must not move while SCL is held high
  logic prev_oe = 0, prev_scl = 1;
  always @(negedge clk) begin
    if (rst_n && scl_m && prev_scl && sda_oe != prev_oe) viol++;
    prev_oe  = sda_oe;
    prev_scl = scl_m;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic i2c_start();
    sda_m = 1; scl_m = 1; wait_n(HP);
    sda_m = 0; wait_n(HP);
    scl_m = 0; wait_n(QP);
  endtask

  task automatic i2c_rstart();
    sda_m = 1; wait_n(HP);
    scl_m = 1; wait_n(HP);
    sda_m = 0; wait_n(HP);
    scl_m = 0; wait_n(QP);
  endtask

  task automatic i2c_stop();
    sda_m = 0; wait_n(HP);
    scl_m = 1; wait_n(HP);
    sda_m = 1; wait_n(HP);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; wait_n(HP);
      scl_m = 1;    wait_n(HP);
      scl_m = 0;    wait_n(QP);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    send_bits(b, 8);
    sda_m = 1; wait_n(HP);
    scl_m = 1; wait_n(QP);
    ack = ~sda_line; wait_n(QP);
    scl_m = 0; wait_n(QP);
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] b);
    sda_m = 1;
    for (int i = 7; i >= 0; i--) begin
      wait_n(HP);
      scl_m = 1; wait_n(QP);
      b[i] = sda_line; wait_n(QP);
      scl_m = 0;
    end
    wait_n(QP);
    sda_m = ~mack; wait_n(HP);
    scl_m = 1; wait_n(HP);
    scl_m = 0; wait_n(QP);
    sda_m = 1;
  endtask

  task automatic check_regs(input string req);
    for (int k = 0; k < NREG; k++) chk(req, regs[k*8 +: 8], model[k]);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    logic a;
    logic [7:0] d;
    for (int k = 0; k < NREG; k++) model[k] = 8'h00;
    wait_n(3);
    // R1 reset state
    chk("R1 sda_oe after reset", sda_oe, 0);
    chk("R1 regs after reset", (regs == '0), 1);
    rst_n = 1; wait_n(5);
    i2c_start(); send_byte({DEV, 1'b1}, a); recv_byte(0, d); i2c_stop();
    chk("R1 pointer starts at 0x00", d, 8'h00);

    // Vector table: single write, then random read back
    for (int v = 0; v < NVEC; v++) begin
      i2c_start();
      send_byte({DEV, 1'b0}, a); chk("R2 address ACK on match", a, 1);
      send_byte(VEC[v][15:8], a); chk("R3 pointer byte ACK", a, 1);
      send_byte(VEC[v][7:0], a);  chk("R3 data byte ACK", a, 1);
      i2c_stop();
      model[VEC[v][15:8]] = VEC[v][7:0];
      chk("R3 stored value on regs_o", regs[VEC[v][15:8]*8 +: 8], VEC[v][7:0]);
      i2c_start(); send_byte({DEV, 1'b0}, a); send_byte(VEC[v][15:8], a);
      i2c_rstart(); send_byte({DEV, 1'b1}, a); recv_byte(0, d); i2c_stop();
      chk("R6 random read returns written byte", d, VEC[v][7:0]);
    end

    // R2 address mismatch: no ACK, subsequent bytes ignored
    i2c_start(); send_byte({DEV ^ 7'h01, 1'b0}, a);
    chk("R2 no ACK on mismatch", a, 0);
    send_byte(8'h03, a); send_byte(8'hAA, a); i2c_stop();
    check_regs("R2 mismatch stores nothing");

    // R3/R4 burst write across the wrap
    i2c_start(); send_byte({DEV, 1'b0}, a); send_byte(8'h14, a);
    send_byte(8'h11, a); send_byte(8'h22, a); send_byte(8'h33, a); i2c_stop();
    model[20] = 8'h11; model[21] = 8'h22; model[0] = 8'h33;
    check_regs("R4 burst write wraps 0x15 to 0x00");

    // R5 current-address read after the write (pointer now 0x01)
    i2c_start(); send_byte({DEV, 1'b1}, a); recv_byte(0, d); i2c_stop();
    chk("R5 current read after write", d, model[1]);
    chk("R7 SDA released after STOP", sda_oe, 0);

    // R6/R7/R4 random read burst through the wrap
    i2c_start(); send_byte({DEV, 1'b0}, a); send_byte(8'h14, a);
    i2c_rstart(); send_byte({DEV, 1'b1}, a);
    recv_byte(1, d); chk("R6 burst byte 0", d, 8'h11);
    recv_byte(1, d); chk("R7 ACK brings next byte", d, 8'h22);
    recv_byte(0, d); chk("R4 read wraps to 0x00", d, 8'h33);
    chk("R7 SDA released after NACK", sda_oe, 0);
    i2c_stop();

    // R5 current read after a read (pointer now 0x01)
    i2c_start(); send_byte({DEV, 1'b1}, a); recv_byte(0, d); i2c_stop();
    chk("R5 current read after read", d, model[1]);

    // R8 out-of-range pointer
    i2c_start(); send_byte({DEV, 1'b0}, a); send_byte(8'h30, a);
    chk("R8 out-of-range pointer ACKed", a, 1);
    send_byte(8'h55, a); chk("R8 out-of-range data ACKed", a, 1);
    i2c_stop();
    check_regs("R8 out-of-range write discarded");
    i2c_start(); send_byte({DEV, 1'b0}, a); send_byte(8'h30, a);
    i2c_rstart(); send_byte({DEV, 1'b1}, a); recv_byte(0, d); i2c_stop();
    chk("R8 out-of-range read is 0x00", d, 8'h00);

    // R10 repeated START in mid-byte keeps the pointer
    i2c_start(); send_byte({DEV, 1'b0}, a); send_byte(8'h07, a); i2c_stop();
    i2c_start(); send_byte({DEV, 1'b0}, a); send_bits(8'hF0, 4);
    i2c_rstart(); send_byte({DEV, 1'b1}, a);
    chk("R10 address ACK after aborted byte", a, 1);
    recv_byte(0, d); i2c_stop();
    chk("R10 pointer kept across START", d, model[7]);
    check_regs("R10 aborted byte stores nothing");

    chk("R9 sda_oe steady while SCL high", viol, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule